// File: doc/BRIEF.md
# Four-Function ALU with Condition Flags

This block is the arithmetic logic unit of a small teaching processor. It takes two operand words, A and B, and a 4-bit function selector. It returns a result word together with overflow, zero and carry flags, which a later pipeline stage may latch. The block has no clock and holds no state. Every output is a pure function of the present inputs and settles in the same evaluation in which an input changes.

Four selector values are legal: 0 adds the operands, 1 subtracts A from B, 2 forms the bitwise AND and 3 forms the bitwise XOR. Any other selector value is rejected. For a rejected value the result and the arithmetic flags are cleared and a separate error line is raised.

Top module: `alu4_core`

## Requirements
- R1: With func_sel = 0 the result is B + A, taken modulo 2^32.
- R2: With func_sel = 1 the result is B − A, taken modulo 2^32. B is the minuend.
- R3: With func_sel = 2 the result is A AND B, bit by bit.
- R4: With func_sel = 3 the result is A XOR B, bit by bit.
- R5: flag_zf is 1 exactly when all 32 result bits are 0, for every selector value.
- R6: For selector 0, flag_of is 1 when A and B share a sign bit (bit 31) and the result's bit 31 differs from it. For selector 1, flag_of is 1 when bit 31 of B differs from bit 31 of A and the result's bit 31 differs from bit 31 of B.
- R7: For selector 0, flag_cf is the carry out of bit 31. For selector 1, flag_cf is 1 when B < A as unsigned numbers, which is a borrow.
- R8: For selectors 2 and 3, flag_of and flag_cf are 0.
- R9: For selector values 4 to 15, the result is 0, flag_of and flag_cf are 0, flag_zf is 1 and func_bad is 1. For selector values 0 to 3, func_bad is 0.
- R10: The outputs follow any change of the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | Operand A. It is the subtrahend for selector 1. |
| opnd_b | input | 32 | Operand B. It is the minuend for selector 1. |
| func_sel | input | 4 | Function selector: 0 add, 1 subtract, 2 AND, 3 XOR. Values 4 to 15 are illegal. |
| result | output | 32 | Result word. |
| flag_of | output | 1 | Signed overflow. |
| flag_zf | output | 1 | Result is zero. |
| flag_cf | output | 1 | Unsigned carry (add) or borrow (subtract). |
| func_bad | output | 1 | Selector value is illegal. |

## Verification
The immediate checks take for granted that every input carries a defined 0 or 1 value. They also assume the design is fully settled when they are evaluated. Because the block has no clock, no sampling instant is implied. The stimulus therefore changes the inputs only in groups, between clock edges. It then waits a fixed delay before it reads any output, so no check sees a half-updated selector or operand. Every vector is fully defined, and the selector sweep includes all twelve illegal values.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
    localparam int FUNC_W = 4;

    typedef enum logic [FUNC_W-1:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_XOR = 4'd3
    } alu_fn_e;

    typedef struct packed {
        logic ovf;
        logic zero;
        logic carry;
    } alu_flags_t;
endpackage

// File: rtl/alu4_arith.sv
module alu4_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         cf,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] a_eff;
    logic [W:0]   wide;

    always_comb begin
        // Subtraction computes b + ~a + 1.
        a_eff = do_sub ? ~a : a;
        wide  = {1'b0, b} + {1'b0, a_eff} + {{W{1'b0}}, do_sub};
        sum   = wide[MSB:0];
        // A carry out during subtraction means no borrow occurred.
        cf    = wide[W] ^ do_sub;
        ovf   = (b[MSB] == a_eff[MSB]) && (wide[MSB] != b[MSB]);
    end
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         pick_xor,
    output logic [W-1:0] out
);
    always_comb begin
        out = pick_xor ? (a ^ b) : (a & b);
    end
endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import alu4_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    input  logic [FUNC_W-1:0] func_sel,
    output logic [W-1:0]      result,
    output logic              flag_of,
    output logic              flag_zf,
    output logic              flag_cf,
    output logic              func_bad
);
    logic [W-1:0] arith_sum;
    logic [W-1:0] logic_out;
    logic         arith_cf;
    logic         arith_ovf;
    alu_flags_t   flags;

    alu4_arith #(.W(W)) u_arith (
        .a      (opnd_a),
        .b      (opnd_b),
        .do_sub (func_sel == FN_SUB),
        .sum    (arith_sum),
        .cf     (arith_cf),
        .ovf    (arith_ovf)
    );

    alu4_logic #(.W(W)) u_logic (
        .a        (opnd_a),
        .b        (opnd_b),
        .pick_xor (func_sel == FN_XOR),
        .out      (logic_out)
    );

    always_comb begin
        result      = '0;
        flags.ovf   = 1'b0;
        flags.carry = 1'b0;
        func_bad    = 1'b0;
        unique case (func_sel)
            FN_ADD, FN_SUB: begin
                result      = arith_sum;
                flags.ovf   = arith_ovf;
                flags.carry = arith_cf;
            end
            FN_AND, FN_XOR: begin
                result = logic_out;
            end
            default: begin
                func_bad = 1'b1;
            end
        endcase
        flags.zero = ~|result;
    end

    assign flag_of = flags.ovf;
    assign flag_zf = flags.zero;
    assign flag_cf = flags.carry;
endmodule

// File: rtl/alu4_chk.sv
module alu4_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [3:0]   func_sel,
    input logic [W-1:0] result,
    input logic         flag_of,
    input logic         flag_zf,
    input logic         flag_cf,
    input logic         func_bad
);
    localparam int MSB = W - 1;

    always_comb begin
        // R1
        add_result_chk: assert (func_sel != 4'd0 || result == opnd_b + opnd_a);
        // R2
        sub_result_chk: assert (func_sel != 4'd1 || result == opnd_b - opnd_a);
        // R5
        zero_flag_chk: assert (flag_zf == (result == '0));
        // R6
        sub_overflow_chk: assert (func_sel != 4'd1 ||
            flag_of == ((opnd_b[MSB] != opnd_a[MSB]) && (result[MSB] != opnd_b[MSB])));
        // R7
        sub_borrow_chk: assert (func_sel != 4'd1 || flag_cf == (opnd_b < opnd_a));
        // R8
        logic_flags_chk: assert (!(func_sel == 4'd2 || func_sel == 4'd3) || (!flag_of && !flag_cf));
        // R9
        bad_code_chk: assert (func_bad == (func_sel > 4'd3));
        // R9
        bad_quiet_chk: assert (!func_bad || (result == '0 && !flag_of && !flag_cf));
    end
endmodule

bind alu4_core alu4_chk #(.W(W)) u_chk (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .func_sel (func_sel),
    .result   (result),
    .flag_of  (flag_of),
    .flag_zf  (flag_zf),
    .flag_cf  (flag_cf),
    .func_bad (func_bad)
);

// File: tb/tb_alu4_core.sv
`timescale 1ns/1ps
module tb_alu4_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  func_sel = '0;
    logic [31:0] result;
    logic        flag_of, flag_zf, flag_cf, func_bad;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    int          cycles = 0;

    always #5 clk = ~clk;

    alu4_core dut (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .func_sel(func_sel),
        .result(result), .flag_of(flag_of), .flag_zf(flag_zf),
        .flag_cf(flag_cf), .func_bad(func_bad)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 5000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Flags are compared packed as {func_bad, of, zf, cf}.
    task automatic chk(string req, logic [31:0] res_exp, logic [3:0] fl_exp);
        checks = checks + 1;
        if (result !== res_exp || {func_bad, flag_of, flag_zf, flag_cf} !== fl_exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h/%b expected %h/%b", req, result,
                     {func_bad, flag_of, flag_zf, flag_cf}, res_exp, fl_exp);
        end
    endtask

    task automatic drive(logic [3:0] f, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        func_sel = f; opnd_a = a; opnd_b = b;
        #1;
    endtask

    task automatic t_idle;
        drive(4'd0, 32'h0, 32'h0);
        chk("R5 idle", 32'h0, 4'b0010);
    endtask

    task automatic t_add;
        drive(4'd0, 32'd7, 32'd5);                   chk("R1 add", 32'd12, 4'b0000);
        drive(4'd0, 32'h1, 32'hFFFF_FFFF);           chk("R7 add carry", 32'h0, 4'b0011);
        drive(4'd0, 32'h1, 32'h7FFF_FFFF);           chk("R6 add ovf", 32'h8000_0000, 4'b0100);
        drive(4'd0, 32'h8000_0000, 32'h8000_0000);   chk("R6 R7 add both", 32'h0, 4'b0111);
    endtask

    task automatic t_sub;
        drive(4'd1, 32'd3, 32'd10);                  chk("R2 sub", 32'd7, 4'b0000);
        drive(4'd1, 32'd10, 32'd3);                  chk("R7 sub borrow", 32'hFFFF_FFF9, 4'b0001);
        drive(4'd1, 32'h1, 32'h8000_0000);           chk("R6 sub ovf", 32'h7FFF_FFFF, 4'b0100);
        drive(4'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF);   chk("R6 R7 sub both", 32'h8000_0000, 4'b0101);
        drive(4'd1, 32'h1234, 32'h1234);             chk("R5 sub zero", 32'h0, 4'b0010);
    endtask

    task automatic t_logic;
        drive(4'd2, 32'hF0F0_F0F0, 32'hFF00_FF00);   chk("R3 and", 32'hF000_F000, 4'b0000);
        drive(4'd2, 32'hFFFF_FFFF, 32'h0);           chk("R5 R8 and zero", 32'h0, 4'b0010);
        drive(4'd3, 32'hAAAA_5555, 32'hFFFF_0000);   chk("R4 xor", 32'h5555_5555, 4'b0000);
        drive(4'd3, 32'h8000_0001, 32'h8000_0001);   chk("R8 xor zero", 32'h0, 4'b0010);
    endtask

    task automatic t_bad;
        for (int f = 4; f < 16; f++) begin
            drive(4'(f), 32'hFFFF_FFFF, 32'h8000_0000);
            chk("R9 illegal code", 32'h0, 4'b1010);
        end
    endtask

    task automatic t_follow;
        // R10: inputs change twice with no clock edge in between.
        @(negedge clk);
        func_sel = 4'd0; opnd_a = 32'd1; opnd_b = 32'd2;
        #1 chk("R10 first", 32'd3, 4'b0000);
        func_sel = 4'd3; opnd_a = 32'hF; opnd_b = 32'hF;
        #1 chk("R10 second", 32'h0, 4'b0010);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_idle;
        t_add;
        t_sub;
        t_logic;
        t_bad;
        t_follow;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule